// File: doc/BRIEF.md
# Half-Bridge Phase Fault and Over-Temperature Monitor

This block watches three comparator flags from a half-bridge power stage together with a die-temperature code, and decides when a single active-low fault line must be pulled down. The flags indicate that the high-side switch is shorted (the switch node sits near the input rail while the high-side gate is off), that the low-side switch is shorted (the switch node sits above ground while the low-side gate is on), or that the low-side switch is open (the switch node falls well below ground while the low-side gate is on). The analog comparators and the temperature sensor sit outside the block.

A switch fault counts only once it has persisted through a run of PWM periods. A period is marked by a high-to-low transition of the PWM input. Once qualified, a switch fault stays latched until reset. Over-temperature uses separate set and clear thresholds and is not latched. The block never drives the line high: it only requests a pull-down or releases the line. It also reports the most important active cause on a 3-bit code.

Top module: `phase_fault_monitor`

## Requirements
- R1: After reset, and whenever no fault is active, `flt_pull_low` is 0 (line released) and `fault_cause` is 0. `flt_pull_low` is 1 exactly when a latched switch fault or the thermal flag is active.
- R2: `fault_cause` codes are 1 for a high-side short, 2 for a low-side short, 3 for a low-side open and 4 for over-temperature. When several are active, the lowest non-zero code is reported.
- R3: A PWM falling edge is a clock where `pwm_in` is 0 and it was 1 on the previous clock. A window runs from one falling-edge clock up to, but not including, the next. A switch fault latches on the falling edge that closes the 15th consecutive window in which its flag was sampled, and it is visible right after that clock. Fourteen windows are not enough.
- R4: The high-side short flag is sampled only while `hs_gate_on` is 0. The low-side short and open flags are sampled only while `ls_gate_on` is 1. Flags seen at any other time have no effect.
- R5: A window that closes without a qualifying sample returns the count for that flag to zero.
- R6: A latched switch fault holds `flt_pull_low` at 1 until reset, whatever the flags and the temperature do.
- R7: When `temp_code` (unsigned, in degrees C) is 115 or more at a clock, the thermal flag is set after that clock.
- R8: The thermal flag clears after a clock where `temp_code` is 95 or less. For codes from 96 to 114 it keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Logic-level PWM command; a high-to-low transition ends a period |
| hs_gate_on | input | 1 | High-side gate drive is on |
| ls_gate_on | input | 1 | Low-side gate drive is on |
| hs_short_flag | input | 1 | Comparator: switch node near the input rail |
| ls_short_flag | input | 1 | Comparator: switch node above the ground threshold |
| ls_open_flag | input | 1 | Comparator: switch node well below ground |
| temp_code | input | 8 | Die temperature, unsigned degrees C |
| flt_pull_low | output | 1 | 1 = pull the fault line low, 0 = release it |
| fault_cause | output | 3 | Highest-priority active cause (see R2) |

## Verification
A counter that slips by one period shows up at the pins as a pull-down one whole PWM period early or late. It also shows up as a pull-down that never comes, after a run broken by a clean window. So the bench measures 14 and 15 windows exactly and checks the output before and after the closing edge. A gate qualifier inverted by mistake turns flags seen during the wrong gate phase into a fault after 16 periods. A hysteresis flag held in the wrong state is visible on the very next clock, because the output is decoded from registers without further delay. A broken latch appears as the line being released during the clean periods that follow a qualified fault.

// File: rtl/ppf_pkg.sv
package ppf_pkg;
  localparam int NUM_SW = 3;
  localparam int IDX_HS_SHORT = 0;
  localparam int IDX_LS_SHORT = 1;
  localparam int IDX_LS_OPEN  = 2;

  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_HS_SHORT = 3'd1,
    CAUSE_LS_SHORT = 3'd2,
    CAUSE_LS_OPEN  = 3'd3,
    CAUSE_OVERTEMP = 3'd4
  } cause_e;

  // Priority encode: switch faults ahead of thermal, lowest code first (R2)
  function automatic cause_e pick_cause(logic [NUM_SW-1:0] sw, logic hot);
    if (sw[IDX_HS_SHORT])      return CAUSE_HS_SHORT;
    else if (sw[IDX_LS_SHORT]) return CAUSE_LS_SHORT;
    else if (sw[IDX_LS_OPEN])  return CAUSE_LS_OPEN;
    else if (hot)              return CAUSE_OVERTEMP;
    else                       return CAUSE_NONE;
  endfunction
endpackage

// File: rtl/pwm_fall_detect.sv
module pwm_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  output logic fall_o
);
  logic pwm_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_prev <= 1'b0;
    else        pwm_prev <= pwm_in;
  end

  assign fall_o = pwm_prev & ~pwm_in;
endmodule

// File: rtl/fault_qualifier.sv
module fault_qualifier #(
  parameter int QUAL_CYCLES = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  input  logic sample_i,
  output logic latched_o
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic          seen;
  logic [CW-1:0] run_cnt;
  logic          latched;

  // Count of consecutive flagged windows; saturates at the last step
  function automatic logic [CW-1:0] next_count(logic hit, logic [CW-1:0] c);
    if (!hit)           return '0;
    else if (c == LAST) return c;
    else                return c + 1'b1;
  endfunction

  function automatic logic qualifies(logic hit, logic [CW-1:0] c);
    return hit && (c == LAST);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      run_cnt <= '0;
      latched <= 1'b0;
    end else if (fall_i) begin
      run_cnt <= next_count(seen, run_cnt);
      latched <= latched | qualifies(seen, run_cnt);
      seen    <= sample_i;
    end else begin
      seen    <= seen | sample_i;
    end
  end

  assign latched_o = latched;
endmodule

// File: rtl/thermal_hysteresis.sv
module thermal_hysteresis #(
  parameter int TEMP_W   = 8,
  parameter int TEMP_SET = 115,
  parameter int TEMP_CLR = 95
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              hot_o
);
  localparam logic [TEMP_W-1:0] SET_CODE = TEMP_W'(TEMP_SET);
  localparam logic [TEMP_W-1:0] CLR_CODE = TEMP_W'(TEMP_CLR);

  logic hot;

  function automatic logic hot_next(logic cur, logic [TEMP_W-1:0] t);
    if (t >= SET_CODE)      return 1'b1;
    else if (t <= CLR_CODE) return 1'b0;
    else                    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hot <= 1'b0;
    else        hot <= hot_next(hot, temp_i);
  end

  assign hot_o = hot;
endmodule

// File: rtl/phase_fault_monitor.sv
module phase_fault_monitor
  import ppf_pkg::*;
#(
  parameter int QUAL_CYCLES = 15,
  parameter int TEMP_W      = 8,
  parameter int TEMP_SET    = 115,
  parameter int TEMP_CLR    = 95
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_in,
  input  logic              hs_gate_on,
  input  logic              ls_gate_on,
  input  logic              hs_short_flag,
  input  logic              ls_short_flag,
  input  logic              ls_open_flag,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              flt_pull_low,
  output logic [2:0]        fault_cause
);
  // Named internal events, observed by the bound checker
  logic              pwm_fall;
  logic [NUM_SW-1:0] sw_sample;
  logic [NUM_SW-1:0] sw_latched;
  logic              therm_flag;
  cause_e            cause;

  pwm_fall_detect u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwm_in (pwm_in),
    .fall_o (pwm_fall)
  );

  // Gate-phase qualification of each comparator (R4)
  always_comb begin
    sw_sample               = '0;
    sw_sample[IDX_HS_SHORT] = hs_short_flag & ~hs_gate_on;
    sw_sample[IDX_LS_SHORT] = ls_short_flag &  ls_gate_on;
    sw_sample[IDX_LS_OPEN]  = ls_open_flag  &  ls_gate_on;
  end

  for (genvar g = 0; g < NUM_SW; g++) begin : g_qual
    fault_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .fall_i    (pwm_fall),
      .sample_i  (sw_sample[g]),
      .latched_o (sw_latched[g])
    );
  end

  thermal_hysteresis #(
    .TEMP_W   (TEMP_W),
    .TEMP_SET (TEMP_SET),
    .TEMP_CLR (TEMP_CLR)
  ) u_therm (
    .clk    (clk),
    .rst_n  (rst_n),
    .temp_i (temp_code),
    .hot_o  (therm_flag)
  );

  assign cause        = pick_cause(sw_latched, therm_flag);
  assign fault_cause  = cause;
  assign flt_pull_low = (|sw_latched) | therm_flag;
endmodule

// File: rtl/phase_fault_monitor_chk.sv
module phase_fault_monitor_chk #(
  parameter int TEMP_W   = 8,
  parameter int TEMP_SET = 115,
  parameter int TEMP_CLR = 95
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwm_fall,
  input logic [2:0]        sw_latched,
  input logic              therm_flag,
  input logic [TEMP_W-1:0] temp_code,
  input logic              flt_pull_low,
  input logic [2:0]        fault_cause
);
  localparam logic [TEMP_W-1:0] SET_CODE = TEMP_W'(TEMP_SET);
  localparam logic [TEMP_W-1:0] CLR_CODE = TEMP_W'(TEMP_CLR);

  // R1: released line reports no cause, pulled line reports one
  assert_release_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_pull_low |-> fault_cause == 3'd0);
  assert_pull_has_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flt_pull_low |-> fault_cause != 3'd0);

  // R3: a switch fault only appears after a PWM falling-edge clock
  assert_qual_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_latched != $past(sw_latched)) |-> $past(pwm_fall));

  // R6: latched switch faults never drop before reset
  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|sw_latched) |=> (|sw_latched) && flt_pull_low);

  // R7: hot code sets the flag on the next clock
  assert_therm_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code >= SET_CODE) |=> therm_flag);

  // R8: cold code clears it; codes between hold it
  assert_therm_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code <= CLR_CODE) |=> !therm_flag);
  assert_therm_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code > CLR_CODE && temp_code < SET_CODE) |=> $stable(therm_flag));
endmodule

bind phase_fault_monitor phase_fault_monitor_chk #(
  .TEMP_W   (TEMP_W),
  .TEMP_SET (TEMP_SET),
  .TEMP_CLR (TEMP_CLR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwm_fall     (pwm_fall),
  .sw_latched   (sw_latched),
  .therm_flag   (therm_flag),
  .temp_code    (temp_code),
  .flt_pull_low (flt_pull_low),
  .fault_cause  (fault_cause)
);

// File: tb/phase_fault_monitor_test.sv
module phase_fault_monitor_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm = 1'b1;
  logic       hs_gate = 1'b1;
  logic       ls_gate = 1'b0;
  logic       hs_sc = 1'b0;
  logic       ls_sc = 1'b0;
  logic       ls_op = 1'b0;
  logic [7:0] temp = 8'd25;
  logic       pull_low;
  logic [2:0] cause;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #2.5ns clk = ~clk;

  phase_fault_monitor uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwm_in        (pwm),
    .hs_gate_on    (hs_gate),
    .ls_gate_on    (ls_gate),
    .hs_short_flag (hs_sc),
    .ls_short_flag (ls_sc),
    .ls_open_flag  (ls_op),
    .temp_code     (temp),
    .flt_pull_low  (pull_low),
    .fault_cause   (cause)
  );

  // Thermal sequence: {temp, expected hot flag} (R7, R8)
  localparam logic [8:0] THERM_TV [12] = '{
    {8'd25, 1'b0}, {8'd114, 1'b0}, {8'd115, 1'b1}, {8'd100, 1'b1},
    {8'd96, 1'b1}, {8'd95, 1'b0},  {8'd110, 1'b0}, {8'd200, 1'b1},
    {8'd96, 1'b1}, {8'd0, 1'b0},   {8'd255, 1'b1}, {8'd95, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_out(input string tag, input int exp_pull, input int exp_cause);
    check(pull_low == exp_pull[0], {tag, " pull"}, int'(pull_low), exp_pull);
    check(cause == exp_cause[2:0], {tag, " cause"}, int'(cause), exp_cause);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pwm = 1'b1; hs_gate = 1'b1; ls_gate = 1'b0;
    hs_sc = 1'b0; ls_sc = 1'b0; ls_op = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // One PWM period: low phase (low-side gate on), then high phase.
  // Flag bits: [0] high-side short, [1] low-side short, [2] low-side open
  task automatic pwm_period(input logic [2:0] lo_f, input logic [2:0] hi_f);
    pwm = 1'b0; hs_gate = 1'b0; ls_gate = 1'b1;
    hs_sc = lo_f[0]; ls_sc = lo_f[1]; ls_op = lo_f[2];
    repeat (2) @(negedge clk);
    pwm = 1'b1; hs_gate = 1'b1; ls_gate = 1'b0;
    hs_sc = hi_f[0]; ls_sc = hi_f[1]; ls_op = hi_f[2];
    repeat (2) @(negedge clk);
    hs_sc = 1'b0; ls_sc = 1'b0; ls_op = 1'b0;
  endtask

  task automatic periods(input int n, input logic [2:0] lo_f, input logic [2:0] hi_f);
    for (int i = 0; i < n; i++) pwm_period(lo_f, hi_f);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    expect_out("R1 reset", 0, 0);

    // Table-driven thermal hysteresis
    for (int i = 0; i < 12; i++) begin
      temp = THERM_TV[i][8:1];
      @(negedge clk);
      expect_out($sformatf("R7/R8 temp=%0d", THERM_TV[i][8:1]),
                 int'(THERM_TV[i][0]), THERM_TV[i][0] ? 4 : 0);
    end
    temp = 8'd25;
    @(negedge clk);
    expect_out("R1 cool idle", 0, 0);

    // R3: fourteen windows are not enough
    periods(14, 3'b001, 3'b000);
    periods(1, 3'b000, 3'b000);
    expect_out("R3 fourteen windows", 0, 0);
    // R3: fifteen windows, before and after the closing edge
    periods(15, 3'b001, 3'b000);
    expect_out("R3 before closing edge", 0, 0);
    periods(1, 3'b000, 3'b000);
    expect_out("R3 R2 high-side short latched", 1, 1);
    periods(5, 3'b000, 3'b000);
    expect_out("R6 latch holds", 1, 1);
    do_reset();
    expect_out("R6 reset clears", 0, 0);

    // R4: flags during the wrong gate phase are ignored
    periods(20, 3'b000, 3'b111);
    periods(1, 3'b000, 3'b000);
    expect_out("R4 off-phase flags", 0, 0);

    // R5: a clean window breaks the run
    periods(10, 3'b010, 3'b000);
    periods(1, 3'b000, 3'b000);
    periods(14, 3'b010, 3'b000);
    periods(1, 3'b000, 3'b000);
    expect_out("R5 broken run", 0, 0);
    periods(15, 3'b010, 3'b000);
    periods(1, 3'b000, 3'b000);
    expect_out("R2 low-side short", 1, 2);
    do_reset();

    // Low-side open, then thermal while latched
    periods(15, 3'b100, 3'b000);
    periods(1, 3'b000, 3'b000);
    expect_out("R2 low-side open", 1, 3);
    temp = 8'd120;
    @(negedge clk);
    expect_out("R2 switch over thermal", 1, 3);
    temp = 8'd30;
    @(negedge clk);
    expect_out("R6 latched through cooling", 1, 3);
    do_reset();

    // Two causes at once: lowest code wins
    periods(15, 3'b101, 3'b000);
    periods(1, 3'b000, 3'b000);
    expect_out("R2 priority high-side first", 1, 1);
    do_reset();

    // Thermal alone clears by hysteresis, no latch
    temp = 8'd130;
    @(negedge clk);
    expect_out("R7 thermal only", 1, 4);
    temp = 8'd100;
    periods(2, 3'b000, 3'b000);
    expect_out("R8 thermal held in band", 1, 4);
    temp = 8'd90;
    @(negedge clk);
    expect_out("R8 thermal cleared", 0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule